// File: doc/BRIEF.md
# Status Register and Write-Protection Unit

This block keeps the eight-bit configuration and status byte of a serial memory and decides, cycle by cycle, whether a requested write may go ahead. The byte holds a write-enable latch, a software flag, two watchdog period bits, two block-lock bits, a lock-enable bit and a busy bit. Its inputs are single-cycle command strobes that an upstream decoder produces: set latch, clear latch and flag, set flag, write status byte, and write array (with its address). A hardware protect pin also comes in.

A write that is granted starts an internal self-timed cycle of `CYC_LEN` clocks. During that cycle the busy bit reads 1 and every new write request is refused. When the cycle ends, the write-enable latch clears. A status-byte write stores its new configuration bits only at that point. An array write leaves the configuration unchanged, and this block only gives the grant for it. The serial shifter and the memory array are outside this block.

Top module: `stat_guard`

## Requirements
- R1: After synchronous reset every bit of `status_q` is 0 and `busy` is 0.
- R2: `cmd_wen_set` sets the write-enable bit (status bit 1) and `cmd_wen_clr` clears it. Both take effect on the next clock edge.
- R3: `cmd_flag_set` sets the flag (status bit 6) and `cmd_wen_clr` clears it. Bit 6 of written status data is ignored, so a status write leaves the flag unchanged.
- R4: A granted status write stores data bits 7 (lock enable), 5:4 (watchdog period) and 3:2 (block-lock code) when the cycle completes. Data bits 1:0 are ignored.
- R5: A granted write makes `busy` and status bit 0 read 1 for exactly `CYC_LEN` clock cycles, starting with the cycle after the request.
- R6: When a write cycle completes, the write-enable bit reads 0.
- R7: A status or array write requested while the write-enable bit is 0 is refused: `busy` stays 0 and the status byte is unchanged.
- R8: The block-lock code protects these addresses of the 2^ADDR_W space: code 0 none, code 1 the top quarter, code 2 the top half, code 3 all. For ADDR_W=11 these are none, 0x600–0x7FF, 0x400–0x7FF and 0x000–0x7FF. `arr_wr_ok` is 0 for a protected `arr_addr`.
- R9: `arr_wr_ok` is 1 only when the write-enable bit is 1, `busy` is 0 and the address is unprotected.
- R10: With lock enable 1 and `wp_pin` low, `stat_wr_ok` is 0 and status writes are refused. With `wp_pin` high or lock enable 0, `stat_wr_ok` follows write-enable and not busy.
- R11: Driving `wp_pin` low while a status write cycle is running does not stop that write from storing its data.
- R12: Write requests that arrive while `busy` is 1 are ignored. They neither lengthen the running cycle nor change the stored configuration.
- R13: When a set strobe and `cmd_wen_clr` arrive in the same cycle, the clear wins for both the write-enable bit and the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wen_set | input | 1 | Strobe: set write-enable latch |
| cmd_wen_clr | input | 1 | Strobe: clear write-enable latch and flag |
| cmd_flag_set | input | 1 | Strobe: set software flag |
| cmd_stat_wr | input | 1 | Strobe: write status byte with `stat_wdata` |
| stat_wdata | input | 8 | Data for a status write |
| cmd_arr_wr | input | 1 | Strobe: array write request at `arr_addr` |
| arr_addr | input | ADDR_W | Array address under consideration |
| wp_pin | input | 1 | Hardware protect pin, low = protect |
| status_q | output | 8 | Status byte {lock-en, flag, wd[1:0], bl[1:0], wen, busy} |
| arr_wr_ok | output | 1 | Array write permitted at `arr_addr` now |
| stat_wr_ok | output | 1 | Status write permitted now |
| busy | output | 1 | Self-timed write cycle running |

## Verification
The hardest case to reach is the protect pin falling in the middle of a status write that turns lock enable on. To get there, the bench starts that write with the pin high and pulls the pin low on the first busy cycle. It then checks that the data was still stored and that the next status write is refused. A second hard case is a mix of write-enable commands and write requests issued inside a running cycle. The bench counts busy cycles to show that the cycle length does not change and that nothing new is stored. For the protection map, the bench sweeps all four lock codes across the whole address space and compares each address with ranges it computes from the address arithmetic.

// File: rtl/stat_guard_pkg.sv
package stat_guard_pkg;
  localparam int BIT_BUSY  = 0;
  localparam int BIT_WEN   = 1;
  localparam int BIT_BL_LO = 2;
  localparam int BIT_WD_LO = 4;
  localparam int BIT_FLAG  = 6;
  localparam int BIT_LOCK  = 7;

  typedef struct packed {
    logic       lock_en;
    logic [1:0] wd;
    logic [1:0] bl;
  } cfg_t;

  function automatic cfg_t cfg_from_byte(input logic [7:0] d);
    cfg_t c;
    c.lock_en = d[BIT_LOCK];
    c.wd      = d[BIT_WD_LO +: 2];
    c.bl      = d[BIT_BL_LO +: 2];
    return c;
  endfunction
endpackage

// File: rtl/sg_range_dec.sv
module sg_range_dec #(
  parameter int ADDR_W = 11
) (
  input  logic [1:0]        bl,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot
);
  localparam int TOP = ADDR_W - 1;

  logic top_q, top_h;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top_q = addr[TOP] & addr[TOP-1];
      assign top_h = addr[TOP];
    end else begin : g_narrow
      assign top_q = addr[TOP];
      assign top_h = addr[TOP];
    end
  endgenerate

  always_comb begin
    unique case (bl)
      2'b00:   prot = 1'b0;
      2'b01:   prot = top_q;
      2'b10:   prot = top_h;
      default: prot = 1'b1;
    endcase
  end

  always_comb begin
    // R8
    all_locked_chk: assert (!(bl == 2'b11) || prot);
  end
endmodule

// File: rtl/sg_cycle_timer.sv
module sg_cycle_timer #(
  parameter int CYC_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYC_LEN + 1);

  logic [CW-1:0] cnt;

  assign done = busy && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(CYC_LEN);
      end
    end else if (done) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      cnt <= cnt - CW'(1);
    end
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt != '0) && (cnt <= CW'(CYC_LEN)));

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

// File: rtl/sg_prot_gate.sv
module sg_prot_gate (
  input  logic clk,
  input  logic rst,
  input  logic wen,
  input  logic busy,
  input  logic lock_en,
  input  logic wp_pin,
  input  logic addr_prot,
  output logic stat_ok,
  output logic arr_ok
);
  logic idle_en;
  logic hw_lock;

  assign idle_en = wen & ~busy;
  assign hw_lock = lock_en & ~wp_pin;
  assign stat_ok = idle_en & ~hw_lock;
  assign arr_ok  = idle_en & ~addr_prot;

  // R10
  hw_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_en && !wp_pin) |-> !stat_ok);

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(arr_ok || stat_ok));
endmodule

// File: rtl/stat_guard.sv
module stat_guard
  import stat_guard_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int CYC_LEN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wen_set,
  input  logic              cmd_wen_clr,
  input  logic              cmd_flag_set,
  input  logic              cmd_stat_wr,
  input  logic [7:0]        stat_wdata,
  input  logic              cmd_arr_wr,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              wp_pin,
  output logic [7:0]        status_q,
  output logic              arr_wr_ok,
  output logic              stat_wr_ok,
  output logic              busy
);
  cfg_t cfg, pend;
  logic wen, flag, pend_is_stat;
  logic addr_prot, cyc_done;
  logic go_stat, go_arr, go_any;

  assign go_stat = cmd_stat_wr & stat_wr_ok;
  assign go_arr  = cmd_arr_wr & arr_wr_ok & ~cmd_stat_wr;
  assign go_any  = go_stat | go_arr;

  sg_range_dec #(.ADDR_W(ADDR_W)) u_range (
    .bl   (cfg.bl),
    .addr (arr_addr),
    .prot (addr_prot)
  );

  sg_prot_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .wen       (wen),
    .busy      (busy),
    .lock_en   (cfg.lock_en),
    .wp_pin    (wp_pin),
    .addr_prot (addr_prot),
    .stat_ok   (stat_wr_ok),
    .arr_ok    (arr_wr_ok)
  );

  sg_cycle_timer #(.CYC_LEN(CYC_LEN)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (go_any),
    .busy  (busy),
    .done  (cyc_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg          <= '0;
      pend         <= '0;
      pend_is_stat <= 1'b0;
      wen          <= 1'b0;
      flag         <= 1'b0;
    end else begin
      if (go_stat) begin
        pend         <= cfg_from_byte(stat_wdata);
        pend_is_stat <= 1'b1;
      end else if (go_arr) begin
        pend_is_stat <= 1'b0;
      end
      if (cyc_done && pend_is_stat) cfg <= pend;

      if (cyc_done)         wen <= 1'b0;
      else if (cmd_wen_clr) wen <= 1'b0;
      else if (cmd_wen_set) wen <= 1'b1;

      if (cmd_wen_clr)       flag <= 1'b0;
      else if (cmd_flag_set) flag <= 1'b1;
    end
  end

  always_comb begin
    status_q                  = '0;
    status_q[BIT_LOCK]        = cfg.lock_en;
    status_q[BIT_FLAG]        = flag;
    status_q[BIT_WD_LO +: 2]  = cfg.wd;
    status_q[BIT_BL_LO +: 2]  = cfg.bl;
    status_q[BIT_WEN]         = wen;
    status_q[BIT_BUSY]        = busy;
  end

  // R6
  wen_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wen);

  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(busy) |-> $stable(cfg));

  // R13
  clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_wen_clr |=> !wen && !flag);
endmodule

// File: tb/sim_stat_guard.sv
module sim_stat_guard;
  localparam int AW = 11;
  localparam int L  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wen_set = 0, cmd_wen_clr = 0, cmd_flag_set = 0;
  logic cmd_stat_wr = 0, cmd_arr_wr = 0;
  logic [7:0] stat_wdata = '0;
  logic [AW-1:0] arr_addr = '0;
  logic wp_pin = 1'b1;
  logic [7:0] status_q;
  logic arr_wr_ok, stat_wr_ok, busy;

  int checks = 0, errors = 0, bcnt = 0;

  always #4 clk = ~clk;

  stat_guard #(.ADDR_W(AW), .CYC_LEN(L)) u0 (
    .clk, .rst, .cmd_wen_set, .cmd_wen_clr, .cmd_flag_set,
    .cmd_stat_wr, .stat_wdata, .cmd_arr_wr, .arr_addr, .wp_pin,
    .status_q, .arr_wr_ok, .stat_wr_ok, .busy
  );

  always @(negedge clk) if (busy) bcnt++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic p_set(); cmd_wen_set = 1; tick(); cmd_wen_set = 0; endtask
  task automatic p_clr(); cmd_wen_clr = 1; tick(); cmd_wen_clr = 0; endtask
  task automatic p_flag(); cmd_flag_set = 1; tick(); cmd_flag_set = 0; endtask
  task automatic p_stat(input logic [7:0] d);
    stat_wdata = d; cmd_stat_wr = 1; tick(); cmd_stat_wr = 0;
  endtask
  task automatic wstat(input logic [7:0] d); p_set(); p_stat(d); endtask
  task automatic idle(); repeat (L + 2) tick(); endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) tick();
    rst = 0;
    tick();
    chk("R1 status", status_q, 8'h00);
    chk("R1 busy", busy, 0);

    p_set();  chk("R2 set", status_q, 8'h02);
    p_clr();  chk("R2 clr", status_q, 8'h00);

    p_flag(); chk("R3 flag set", status_q, 8'h40);
    p_set();  chk("R3 both", status_q, 8'h42);
    p_clr();  chk("R3 clr both", status_q, 8'h00);

    cmd_wen_set = 1; cmd_flag_set = 1; cmd_wen_clr = 1; tick();
    cmd_wen_set = 0; cmd_flag_set = 0; cmd_wen_clr = 0;
    chk("R13 clear wins", status_q, 8'h00);

    p_stat(8'hFC);
    chk("R7 stat busy", busy, 0);
    chk("R7 stat unchanged", status_q, 8'h00);
    arr_addr = 5; cmd_arr_wr = 1; tick(); cmd_arr_wr = 0;
    chk("R7 arr busy", busy, 0);

    p_flag();
    bcnt = 0;
    wstat(8'h7F);
    chk("R5 first busy status", status_q, 8'h43);
    for (int i = 0; i < L + 2; i++) begin
      chk("R5 bit0 tracks busy", status_q[0], busy);
      tick();
    end
    chk("R5 busy length", bcnt, L);
    chk("R4 stored", status_q, 8'h7C);
    chk("R6 wen cleared", status_q[1], 0);
    chk("R3 flag kept", status_q[6], 1);

    bcnt = 0;
    wstat(8'h00);
    p_set();
    chk("R12 wen set in cycle", status_q[1], 1);
    stat_wdata = 8'hFC; cmd_stat_wr = 1; tick(); cmd_stat_wr = 0;
    arr_addr = 0; cmd_arr_wr = 1; tick(); cmd_arr_wr = 0;
    idle();
    chk("R12 busy length", bcnt, L);
    chk("R12 cfg from first write", status_q, 8'h40);

    wp_pin = 1;
    p_set();
    stat_wdata = 8'h80; cmd_stat_wr = 1; tick(); cmd_stat_wr = 0;
    wp_pin = 0;
    idle();
    chk("R11 write survived pin", status_q, 8'hC0);
    p_set();
    chk("R10 locked permit", stat_wr_ok, 0);
    p_stat(8'h00);
    chk("R10 locked busy", busy, 0);
    chk("R10 locked status", status_q, 8'hC2);
    wp_pin = 1; tick();
    chk("R10 pin high permit", stat_wr_ok, 1);
    p_stat(8'h00);
    idle();
    chk("R10 unlocked", status_q, 8'h40);
    wp_pin = 0; p_set();
    chk("R10 en0 pin low permit", stat_wr_ok, 1);
    p_clr(); wp_pin = 1;
    chk("R10 no wen permit", stat_wr_ok, 0);

    arr_addr = 5; tick();
    chk("R9 no wen", arr_wr_ok, 0);
    p_set();
    chk("R9 wen", arr_wr_ok, 1);
    cmd_arr_wr = 1; tick(); cmd_arr_wr = 0;
    chk("R9 started", busy, 1);
    chk("R9 busy blocks", arr_wr_ok, 0);
    idle();
    chk("R6 after array", status_q, 8'h00);

    for (int code = 0; code < 4; code++) begin
      wstat(8'(code << 2));
      idle();
      p_set();
      for (int a = 0; a < (1 << AW); a++) begin
        int lim;
        bit prot;
        lim = (code == 0) ? (1 << AW) : (code == 1) ? (3 << (AW - 2)) :
              (code == 2) ? (1 << (AW - 1)) : 0;
        prot = (a >= lim);
        arr_addr = AW'(a);
        #1;
        chk($sformatf("R8 code%0d addr%0h", code, a), arr_wr_ok, !prot);
      end
      tick();
      p_clr();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule